// File: doc/BRIEF.md
# DDR SDRAM Refresh Scheduler

This block keeps a four-bank DDR SDRAM refreshed on behalf of a memory controller. A free-running interval counter adds one owed refresh every refresh interval. Refreshes do not have to be issued the moment they fall due: the main sequencer may postpone them and clear the backlog later in a burst. The owed count saturates at eight, and at that point the request becomes urgent. While the count is above zero, the block asks for the command bus. When the bus is granted and every bank is precharged, it drives one auto-refresh command. After that command it holds off all further commands for the refresh cycle time.

The block also handles self-refresh. When the sequencer asks for self-refresh and grants the bus with all banks precharged, the block drives the entry command with clock enable falling. It then keeps the clock enable low until an exit is requested. After exit it reports separately when an activate is legal and when a read is legal.

The request/grant pair works like a valid/ready pair. `req` stays high until a command has been issued, and nothing is issued unless `gnt` and `banks_idle` are both high at the same edge. The sequencer applies back-pressure by holding `gnt` low. All time values are parameters in picoseconds, with the clock period given the same way. At elaboration each time value becomes a whole number of cycles, rounded up.

Top module: `refresh_sched`

## Requirements
- R1: While reset is active and right after it: `cmd_valid` is 0, `cmd_cs_n` is 1, `cmd_cke` is 1 and `req` is 0.
- R2: Each elapsed refresh interval adds one owed refresh. `req` is 1 from the first cycle after the interval edge for as long as any refresh is owed and no recovery or self-refresh is in progress.
- R3: A command is issued only at a clock edge where `req`, `gnt` and `banks_idle` are all 1. On the next cycle `cmd_valid` is 1 for exactly one cycle with the auto-refresh code: cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=1. When `req` is 0, `gnt` has no effect.
- R4: From the auto-refresh cycle onward, `block_cmd` is 1 and `req`, `act_ok` and `rd_ok` are 0 for ceil(refresh cycle time / clock period) cycles.
- R5: The owed count saturates at 8. `urgent` is 1 exactly while 8 are owed, `act_ok` is 0 while `urgent` is 1, and issuing one refresh clears `urgent`.
- R6: If `sr_enter` is 1 at a firing edge, a self-refresh entry is issued instead of an auto-refresh. It uses the same cs/ras/cas/we code with cke=0. The owed count is cleared, cke stays 0, `block_cmd` stays 1 and the interval counter is held until exit.
- R7: `sr_exit` during self-refresh drives one cycle with cke=1 and cs_n=1, and `cmd_valid` is 1 on that cycle. `act_ok` returns ceil(exit-to-activate time / clock period) cycles after that cycle, and `rd_ok` returns `XSR_CYC` cycles after it. Outside self-refresh, `sr_exit` has no effect.
- R8: The refresh interval restarts at self-refresh exit, so the first owed refresh appears one full interval after the exit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| banks_idle | input | 1 | All four banks are precharged |
| sr_enter | input | 1 | Sequencer asks for self-refresh entry (level) |
| sr_exit | input | 1 | Sequencer asks for self-refresh exit |
| gnt | input | 1 | Command bus granted to this block (ready) |
| req | output | 1 | Command bus wanted (valid) |
| urgent | output | 1 | Owed count is saturated |
| cmd_valid | output | 1 | A command is driven this cycle |
| cmd_cke | output | 1 | Clock enable to the SDRAM |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| block_cmd | output | 1 | No other command may be issued this cycle |
| act_ok | output | 1 | A bank activate is allowed |
| rd_ok | output | 1 | A read is allowed |

## Verification
The bench builds the block with a 4000 ps clock and a 100 ns interval, which gives 25 cycles. The refresh cycle time is 30 ns, which rounds up from 7.5 to 8 cycles and so exercises the rounding. The exit-to-activate time is 20 ns (5 cycles), and reads wait 12 cycles after exit. With a 25-cycle interval the owed count reaches saturation after about two hundred cycles, and the bench holds it there across one more interval. All self-refresh and recovery windows are short enough to check the cycles on both sides of each edge.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ddr_pins_t;

  localparam ddr_pins_t PINS_IDLE = '{cke: 1'b1, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam ddr_pins_t PINS_AREF = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam ddr_pins_t PINS_SREF = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam ddr_pins_t PINS_SLEEP = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/refsched_debt.sv
module refsched_debt #(
  parameter int REFI_CYC = 1040,
  parameter int MAX_OWED = 8,
  localparam int CW = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1,
  localparam int OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          clear,
  input  logic          take,
  output logic [OW-1:0] owed,
  output logic          full
);
  localparam logic [CW-1:0] LAST  = CW'(REFI_CYC - 1);
  localparam logic [OW-1:0] CAP   = OW'(MAX_OWED);

  logic [CW-1:0] tick_cnt;
  logic          tick;

  assign tick = !hold && !clear && (tick_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tick_cnt <= '0;
    else if (hold || clear) tick_cnt <= '0;
    else if (tick)         tick_cnt <= '0;
    else                   tick_cnt <= tick_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        owed <= '0;
    else if (clear)                    owed <= '0;
    else if (tick && !take)            owed <= (owed == CAP) ? CAP : owed + 1'b1;
    else if (!tick && take && owed != '0) owed <= owed - 1'b1;
  end

  assign full = (owed == CAP);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CLK_PS   = 7500,
  parameter int REFI_PS  = 7800000,
  parameter int RFC_PS   = 75000,
  parameter int XSA_PS   = 75000,
  parameter int XSR_CYC  = 200,
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic sr_enter,
  input  logic sr_exit,
  input  logic gnt,
  output logic req,
  output logic urgent,
  output logic cmd_valid,
  output logic cmd_cke,
  output logic cmd_cs_n,
  output logic cmd_ras_n,
  output logic cmd_cas_n,
  output logic cmd_we_n,
  output logic block_cmd,
  output logic act_ok,
  output logic rd_ok
);
  import refsched_pkg::*;

  localparam int REFI_CYC = ps_to_cyc(REFI_PS, CLK_PS);
  localparam int RFC_CYC  = ps_to_cyc(RFC_PS, CLK_PS);
  localparam int XSA_CYC  = ps_to_cyc(XSA_PS, CLK_PS);
  localparam int TMAX     = (RFC_CYC > XSA_CYC) ? ((RFC_CYC > XSR_CYC) ? RFC_CYC : XSR_CYC)
                                                : ((XSA_CYC > XSR_CYC) ? XSA_CYC : XSR_CYC);
  localparam int TW       = $clog2(TMAX + 1);
  localparam int OW       = $clog2(MAX_OWED + 1);

  logic          in_sr;
  logic          rec_busy, xsa_busy, xsr_busy;
  logic [OW-1:0] owed;
  logic          fire, do_aref, do_sref, do_exit;
  ddr_pins_t     pins_q;

  assign req     = !in_sr && !rec_busy && ((owed != '0) || sr_enter);
  assign fire    = req && gnt && banks_idle;
  assign do_sref = fire && sr_enter;
  assign do_aref = fire && !sr_enter;
  assign do_exit = in_sr && sr_exit;

  refsched_debt #(.REFI_CYC(REFI_CYC), .MAX_OWED(MAX_OWED)) u_debt (
    .clk(clk), .rst_n(rst_n), .hold(in_sr), .clear(do_sref),
    .take(do_aref), .owed(owed), .full(urgent)
  );

  refsched_timer #(.W(TW)) u_rfc (
    .clk(clk), .rst_n(rst_n), .load(do_aref), .load_val(TW'(RFC_CYC)), .busy(rec_busy)
  );
  refsched_timer #(.W(TW)) u_xsa (
    .clk(clk), .rst_n(rst_n), .load(do_exit), .load_val(TW'(XSA_CYC)), .busy(xsa_busy)
  );
  refsched_timer #(.W(TW)) u_xsr (
    .clk(clk), .rst_n(rst_n), .load(do_exit), .load_val(TW'(XSR_CYC)), .busy(xsr_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sr     <= 1'b0;
      cmd_valid <= 1'b0;
      pins_q    <= PINS_IDLE;
    end else begin
      cmd_valid <= do_aref || do_sref || do_exit;
      if (do_sref)      in_sr <= 1'b1;
      else if (do_exit) in_sr <= 1'b0;
      if (do_aref)      pins_q <= PINS_AREF;
      else if (do_sref) pins_q <= PINS_SREF;
      else if (do_exit) pins_q <= PINS_IDLE;
      else if (in_sr)   pins_q <= PINS_SLEEP;
      else              pins_q <= PINS_IDLE;
    end
  end

  assign cmd_cke   = pins_q.cke;
  assign cmd_cs_n  = pins_q.cs_n;
  assign cmd_ras_n = pins_q.ras_n;
  assign cmd_cas_n = pins_q.cas_n;
  assign cmd_we_n  = pins_q.we_n;

  assign block_cmd = rec_busy || in_sr;
  assign act_ok    = !block_cmd && !xsa_busy && !urgent;
  assign rd_ok     = !block_cmd && !xsr_busy;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic banks_idle,
  input logic gnt,
  input logic req,
  input logic urgent,
  input logic cmd_valid,
  input logic cmd_cke,
  input logic cmd_cs_n,
  input logic cmd_ras_n,
  input logic cmd_cas_n,
  input logic cmd_we_n,
  input logic block_cmd,
  input logic act_ok,
  input logic rd_ok
);
  // R3: a refresh-type command follows an edge with grant and idle banks
  assert_cmd_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_cs_n) |-> $past(gnt && banks_idle && req));

  // R4: auto-refresh cycle is covered by the command block
  assert_block_on_aref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_cs_n && cmd_cke) |-> (block_cmd && !act_ok && !rd_ok));

  // R4: no new bus request while commands are blocked
  assert_no_req_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    block_cmd |-> !req);

  // R5: saturated debt forbids activates
  assert_urgent_no_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> !act_ok);

  // R6: clock enable only falls with the self-refresh entry code
  assert_cke_fall_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_cke) |-> (cmd_valid && !cmd_cs_n && !cmd_ras_n && !cmd_cas_n && cmd_we_n));

  // R7: exit cycle leaves activate and read disallowed
  assert_exit_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_cke) |-> (cmd_valid && cmd_cs_n && !act_ok && !rd_ok));
endmodule

bind refresh_sched refresh_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .gnt(gnt), .req(req),
  .urgent(urgent), .cmd_valid(cmd_valid), .cmd_cke(cmd_cke), .cmd_cs_n(cmd_cs_n),
  .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
  .block_cmd(block_cmd), .act_ok(act_ok), .rd_ok(rd_ok)
);

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic banks_idle = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0, gnt = 1'b0;
  logic req, urgent, cmd_valid, cmd_cke, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic block_cmd, act_ok, rd_ok;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refresh_sched #(
    .CLK_PS(4000), .REFI_PS(100000), .RFC_PS(30000), .XSA_PS(20000),
    .XSR_CYC(12), .MAX_OWED(8)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .sr_enter(sr_enter),
    .sr_exit(sr_exit), .gnt(gnt), .req(req), .urgent(urgent), .cmd_valid(cmd_valid),
    .cmd_cke(cmd_cke), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
    .cmd_we_n(cmd_we_n), .block_cmd(block_cmd), .act_ok(act_ok), .rd_ok(rd_ok)
  );

  // row = {cycles, gnt idle sre srx, req urg vld cs, cke blk act rd, tag}
  localparam logic [31:0] TBL [20] = '{
    {16'd24,  12'b0100_0001_1011, 4'd2},  // R2 just before first interval edge
    {16'd1,   12'b0100_1001_1011, 4'd2},  // R2 one refresh owed
    {16'd1,   12'b1000_1001_1011, 4'd3},  // R3 grant with busy banks
    {16'd1,   12'b1100_0010_1100, 4'd3},  // R3 auto-refresh issued
    {16'd7,   12'b0100_0001_1100, 4'd4},  // R4 last blocked cycle
    {16'd1,   12'b0100_0001_1011, 4'd4},  // R4 recovery over
    {16'd189, 12'b0100_1001_1011, 4'd5},  // R5 seven owed
    {16'd1,   12'b0100_1101_1001, 4'd5},  // R5 eight owed, urgent
    {16'd25,  12'b0100_1101_1001, 4'd5},  // R5 saturated across a tick
    {16'd1,   12'b1100_0010_1100, 4'd5},  // R5 one issue clears urgency
    {16'd8,   12'b0110_1001_1011, 4'd6},  // R6 self-refresh wanted
    {16'd1,   12'b1110_0010_0100, 4'd6},  // R6 entry issued
    {16'd30,  12'b0100_0001_0100, 4'd6},  // R6 held in self-refresh
    {16'd1,   12'b0101_0011_1000, 4'd7},  // R7 exit cycle
    {16'd4,   12'b0100_0001_1000, 4'd7},  // R7 activate still waiting
    {16'd1,   12'b0100_0001_1010, 4'd7},  // R7 activate allowed
    {16'd6,   12'b0100_0001_1010, 4'd7},  // R7 read still waiting
    {16'd1,   12'b0100_0001_1011, 4'd7},  // R7 read allowed
    {16'd12,  12'b0100_0001_1011, 4'd8},  // R8 interval restarted, none owed
    {16'd1,   12'b0100_1001_1011, 4'd8}   // R8 first owed after exit
  };

  task automatic chk(input string what, input int tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s got %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("valid in reset", 1, cmd_valid, 1'b0);
    chk("cs_n in reset", 1, cmd_cs_n, 1'b1);
    chk("cke in reset", 1, cmd_cke, 1'b1);
    chk("req in reset", 1, req, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < 20; i++) begin
      logic [11:0] b;
      int tg;
      b  = TBL[i][15:4];
      tg = int'(TBL[i][3:0]);
      gnt = b[11]; banks_idle = b[10]; sr_enter = b[9]; sr_exit = b[8];
      repeat (int'(TBL[i][31:16])) @(negedge clk);
      chk("req", tg, req, b[7]);
      chk("urgent", tg, urgent, b[6]);
      chk("cmd_valid", tg, cmd_valid, b[5]);
      chk("cs_n", tg, cmd_cs_n, b[4]);
      chk("cke", tg, cmd_cke, b[3]);
      chk("block_cmd", tg, block_cmd, b[2]);
      chk("act_ok", tg, act_ok, b[1]);
      chk("rd_ok", tg, rd_ok, b[0]);
      if (b[5] && !b[4]) begin
        chk("ras_n code", tg, cmd_ras_n, 1'b0);
        chk("cas_n code", tg, cmd_cas_n, 1'b0);
        chk("we_n code", tg, cmd_we_n, 1'b1);
      end
    end

    // R7 exit request outside self-refresh is ignored
    gnt = 1'b0; sr_exit = 1'b1;
    @(negedge clk);
    chk("stray exit valid", 7, cmd_valid, 1'b0);
    chk("stray exit cke", 7, cmd_cke, 1'b1);
    sr_exit = 1'b0;

    // R3 owed refresh issued on grant
    gnt = 1'b1;
    @(negedge clk);
    chk("issue valid", 3, cmd_valid, 1'b1);
    chk("issue cs_n", 3, cmd_cs_n, 1'b0);

    // R3 grant with nothing owed does nothing
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("idle grant valid", 3, cmd_valid, 1'b0);
    end
    gnt = 1'b0;

    // R1 reset mid-run
    rst_n = 1'b0;
    #1;
    chk("valid after reset", 1, cmd_valid, 1'b0);
    chk("cs_n after reset", 1, cmd_cs_n, 1'b1);
    chk("cke after reset", 1, cmd_cke, 1'b1);
    chk("req after reset", 1, req, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule